// File: doc/BRIEF.md
# Serial DAC Command Word Assembler

This block sits behind a byte-level I2C slave receiver and turns its byte stream into DAC update words. Each update word is 24 bits long and arrives MSB first, in three bytes: a control byte, then the high data byte, then the low data byte. The block splits the control byte into an operation field and a channel field. It takes the data code from the top bits of the 16-bit data field. When a word is complete, it raises a one-cycle strobe.

A flag in the control byte selects streaming. In streaming mode, each further pair of data bytes in the same transaction is a new update word. That word reuses the latched operation and channel, so no new control byte is sent. A transaction start or stop always brings the next byte back to control-byte position. A word whose reserved bit is set raises an error pulse instead of the strobe. Executing the DAC operation is left to the consumer of the outputs.

Top module: `dac_word_asm`

## Requirements
- R1: While rst_ni is low and after reset, word_valid_o and word_err_o are 0, and op_o, chan_o and code_o are all zero.
- R2: Control byte layout: bit 7 is reserved, bit 6 is the stream flag, bits 5..3 are the operation and bits 2..0 are the channel. After a control byte, a high byte and a low byte, word_valid_o is high for exactly the one cycle after the clock edge that accepted the low byte. In that cycle op_o and chan_o show the control byte's fields.
- R3: code_o equals the top RES_BITS bits of {high byte, low byte}, so the lowest 16-RES_BITS bits of the data field are ignored.
- R4: With the stream flag at 0, the byte after a completed word in the same transaction is taken as a new control byte.
- R5: With the stream flag at 1, each later pair of bytes in the same transaction produces another strobe. That strobe carries the latched op_o and chan_o values and the new code.
- R6: A start_i or stop_i pulse drops any partial word without a strobe. The next byte is taken as a control byte.
- R7: A word whose control byte has bit 7 set raises word_err_o for one cycle in place of word_valid_o. op_o, chan_o and code_o keep their previous values.
- R8: op_o, chan_o and code_o change only in a cycle where word_valid_o is high.
- R9: A byte presented in the same cycle as start_i or stop_i is discarded.
- R10: Cycles with byte_valid_i low do not advance the word position, however many of them occur between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A received byte is present this cycle |
| byte_data_i | input | 8 | Received byte |
| start_i | input | 1 | Transaction start or repeated start seen |
| stop_i | input | 1 | Transaction stop seen |
| word_valid_o | output | 1 | One-cycle strobe for a complete, accepted word |
| word_err_o | output | 1 | One-cycle pulse for a complete word with the reserved bit set |
| op_o | output | 3 | Operation field of the accepted word |
| chan_o | output | 3 | Channel field of the accepted word |
| code_o | output | RES_BITS | Data code, top RES_BITS bits of the data field |

## Verification
The bench checks streaming runs that cross several byte pairs. A design that falls back to control-byte position after each word would misread data bytes as a new operation. It cuts transactions after one or two bytes and sends a byte in the same cycle as start. A design that keeps its position or accepts that byte would strobe on a mangled word. It sends reserved-bit words and idle gaps between bytes. Those catch a design that strobes on a bad word, overwrites the held fields, or advances its position without a valid byte.

// File: rtl/dac_asm_pkg.sv
package dac_asm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned CHAN_W = 3;

  typedef enum logic [1:0] {
    PH_CTL = 2'd0,
    PH_HI  = 2'd1,
    PH_LO  = 2'd2
  } phase_e;

  typedef struct packed {
    logic              rsv;
    logic              stream;
    logic [OP_W-1:0]   op;
    logic [CHAN_W-1:0] chan;
  } ctl_byte_t;
endpackage

// File: rtl/dac_byte_seq.sv
module dac_byte_seq
  import dac_asm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_valid_i,
  input  logic clear_i,
  input  logic stream_i,
  output logic take_ctl_o,
  output logic take_hi_o,
  output logic take_lo_o
);
  phase_e phase_q, phase_d;
  logic   accept;

  assign accept     = byte_valid_i & ~clear_i;
  assign take_ctl_o = accept & (phase_q == PH_CTL);
  assign take_hi_o  = accept & (phase_q == PH_HI);
  assign take_lo_o  = accept & (phase_q == PH_LO);

  always_comb begin
    phase_d = phase_q;
    if (clear_i) begin
      phase_d = PH_CTL;
    end else if (accept) begin
      unique case (phase_q)
        PH_CTL:  phase_d = PH_HI;
        PH_HI:   phase_d = PH_LO;
        PH_LO:   phase_d = stream_i ? PH_HI : PH_CTL;
        default: phase_d = PH_CTL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_CTL;
    else         phase_q <= phase_d;
  end

  // R6
  clear_to_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> phase_q == PH_CTL);

  // R5
  stream_reuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_lo_o && stream_i) |=> phase_q == PH_HI);

  // R4
  plain_back_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_lo_o && !stream_i) |=> phase_q == PH_CTL);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_valid_i && !clear_i) |=> $stable(phase_q));
endmodule

// File: rtl/dac_ctl_latch.sv
module dac_ctl_latch
  import dac_asm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_ctl_i,
  input  logic              take_hi_i,
  input  logic [BYTE_W-1:0] byte_i,
  output ctl_byte_t         ctl_o,
  output logic [BYTE_W-1:0] hi_o
);
  ctl_byte_t         ctl_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      hi_q  <= '0;
    end else begin
      if (take_ctl_i) ctl_q <= ctl_byte_t'(byte_i);
      if (take_hi_i)  hi_q  <= byte_i;
    end
  end

  assign ctl_o = ctl_q;
  assign hi_o  = hi_q;

  // R5: control byte only moves when a new one is taken
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_ctl_i |=> $stable(ctl_q));
endmodule

// File: rtl/dac_word_out.sv
module dac_word_out
  import dac_asm_pkg::*;
#(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_lo_i,
  input  ctl_byte_t           ctl_i,
  input  logic [BYTE_W-1:0]   hi_i,
  input  logic [BYTE_W-1:0]   lo_i,
  output logic                valid_o,
  output logic                err_o,
  output logic [OP_W-1:0]     op_o,
  output logic [CHAN_W-1:0]   chan_o,
  output logic [RES_BITS-1:0] code_o
);
  localparam int unsigned PAD_W = DATA_W - RES_BITS;

  generate
    if (!(RES_BITS == 12 || RES_BITS == 14 || RES_BITS == 16)) begin : g_bad_res
      $error("RES_BITS must be 12, 14 or 16");
    end
  endgenerate

  logic [DATA_W-1:0]   data_w;
  logic [RES_BITS-1:0] code_w;
  logic                valid_q, err_q;
  logic [OP_W-1:0]     op_q;
  logic [CHAN_W-1:0]   chan_q;
  logic [RES_BITS-1:0] code_q;

  assign data_w = {hi_i, lo_i};
  assign code_w = data_w[DATA_W-1 -: RES_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      op_q    <= '0;
      chan_q  <= '0;
      code_q  <= '0;
    end else begin
      valid_q <= take_lo_i & ~ctl_i.rsv;
      err_q   <= take_lo_i &  ctl_i.rsv;
      if (take_lo_i && !ctl_i.rsv) begin
        op_q   <= ctl_i.op;
        chan_q <= ctl_i.chan;
        code_q <= code_w;
      end
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign op_o    = op_q;
  assign chan_o  = chan_q;
  assign code_o  = code_q;

  // R8
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> ($stable(code_q) && $stable(op_q) && $stable(chan_q)));

  // R7
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && err_q));

  // R2
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  initial begin
    pad_chk: assert (PAD_W <= 4);
  end
endmodule

// File: rtl/dac_word_asm.sv
module dac_word_asm
  import dac_asm_pkg::*;
#(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                byte_valid_i,
  input  logic [7:0]          byte_data_i,
  input  logic                start_i,
  input  logic                stop_i,
  output logic                word_valid_o,
  output logic                word_err_o,
  output logic [2:0]          op_o,
  output logic [2:0]          chan_o,
  output logic [RES_BITS-1:0] code_o
);
  logic              clear;
  logic              take_ctl, take_hi, take_lo;
  ctl_byte_t         ctl;
  logic [BYTE_W-1:0] hi;

  assign clear = start_i | stop_i;

  dac_byte_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .clear_i      (clear),
    .stream_i     (ctl.stream),
    .take_ctl_o   (take_ctl),
    .take_hi_o    (take_hi),
    .take_lo_o    (take_lo)
  );

  dac_ctl_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_ctl_i (take_ctl),
    .take_hi_i  (take_hi),
    .byte_i     (byte_data_i),
    .ctl_o      (ctl),
    .hi_o       (hi)
  );

  dac_word_out #(.RES_BITS(RES_BITS)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_lo_i (take_lo),
    .ctl_i     (ctl),
    .hi_i      (hi),
    .lo_i      (byte_data_i),
    .valid_o   (word_valid_o),
    .err_o     (word_err_o),
    .op_o      (op_o),
    .chan_o    (chan_o),
    .code_o    (code_o)
  );

  // R9
  strobe_needs_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o || word_err_o) |-> ($past(byte_valid_i) && !$past(clear)));
endmodule

// File: tb/dac_word_asm_tb.sv
module dac_word_asm_tb;
  localparam int unsigned RES = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bv = 1'b0;
  logic [7:0]     bd = '0;
  logic           st = 1'b0;
  logic           sp = 1'b0;
  logic           wv, we;
  logic [2:0]     op, ch;
  logic [RES-1:0] code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int             m_ph = 0;
  logic [7:0]     m_ctl = '0, m_hi = '0;
  logic [2:0]     e_op = '0, e_ch = '0;
  logic [RES-1:0] e_code = '0;

  always #10 clk = ~clk;

  dac_word_asm #(.RES_BITS(RES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_data_i(bd),
    .start_i(st), .stop_i(sp), .word_valid_o(wv), .word_err_o(we),
    .op_o(op), .chan_o(ch), .code_o(code)
  );

  function automatic logic [RES-1:0] f_code(logic [7:0] h, logic [7:0] l);
    logic [15:0] d;
    d = {h, l};
    return d[15 -: RES];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(bit ev, bit ee, string req);
    chk(wv == ev, {req, " valid"}, 32'(wv), 32'(ev));
    chk(we == ee, {req, " err"}, 32'(we), 32'(ee));
    chk(op == e_op && ch == e_ch, {req, " op/chan"}, {26'd0, op, ch}, {26'd0, e_op, e_ch});
    chk(code == e_code, {req, " code"}, 32'(code), 32'(e_code));
  endtask

  // one cycle; optional byte, optional clear
  task automatic cyc(bit v, logic [7:0] b, bit s, bit p, string req);
    bit ev = 0, ee = 0;
    @(negedge clk);
    bv = v; bd = b; st = s; sp = p;
    if (s || p) begin
      m_ph = 0;
    end else if (v) begin
      case (m_ph)
        0: begin m_ctl = b; m_ph = 1; end
        1: begin m_hi = b; m_ph = 2; end
        default: begin
          if (m_ctl[7]) ee = 1;
          else begin
            ev = 1; e_op = m_ctl[5:3]; e_ch = m_ctl[2:0]; e_code = f_code(m_hi, b);
          end
          m_ph = m_ctl[6] ? 1 : 0;
        end
      endcase
    end
    @(posedge clk); #1;
    chk_out(ev, ee, req);
    @(negedge clk);
    bv = 0; st = 0; sp = 0;
  endtask

  task automatic word3(logic [7:0] c, logic [7:0] h, logic [7:0] l, string req);
    cyc(1, c, 0, 0, req);
    cyc(1, h, 0, 0, req);
    cyc(1, l, 0, 0, req);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #5;
    // R1
    #1; chk_out(0, 0, "R1 in reset");
    #40; rst_n = 1'b1;
    @(posedge clk); #1; chk_out(0, 0, "R1 after reset");

    // R2 R3 basic word
    cyc(0, 0, 1, 0, "R2 start");
    word3(8'b0_0_011_101, 8'hAB, 8'hCD, "R2 R3 plain word");
    // R3 ignored low bits: only differs in bottom nibble
    word3(8'b0_0_011_101, 8'hAB, 8'hC3, "R3 pad bits ignored");
    // R4 next byte is control
    word3(8'b0_0_110_010, 8'h12, 8'h34, "R4 new control");
    cyc(0, 0, 0, 1, "R4 stop");

    // R5 streaming
    cyc(0, 0, 1, 0, "R5 start");
    word3(8'b0_1_101_011, 8'h80, 8'h0F, "R5 first");
    cyc(1, 8'hFF, 0, 0, "R5 pair hi");
    cyc(1, 8'hF0, 0, 0, "R5 pair lo");
    cyc(1, 8'h01, 0, 0, "R5 pair2 hi");
    cyc(1, 8'h20, 0, 0, "R5 pair2 lo");

    // R6 cut mid word
    cyc(0, 0, 1, 0, "R6 restart");
    cyc(1, 8'b0_0_001_001, 0, 0, "R6 ctl");
    cyc(1, 8'h55, 0, 0, "R6 hi");
    cyc(0, 0, 0, 1, "R6 stop mid");
    word3(8'b0_0_010_100, 8'h66, 8'h77, "R6 fresh word");
    cyc(1, 8'b0_0_111_111, 0, 0, "R6 ctl2");
    cyc(0, 0, 1, 0, "R6 start mid");
    word3(8'b0_0_100_001, 8'h9A, 8'hBC, "R6 after start");

    // R7 reserved bit
    word3(8'b1_0_111_111, 8'hFF, 8'hFF, "R7 reserved");
    word3(8'b1_1_000_110, 8'h11, 8'h22, "R7 reserved stream");
    cyc(1, 8'h33, 0, 0, "R7 stream hi");
    cyc(1, 8'h44, 0, 0, "R7 stream lo");
    cyc(0, 0, 0, 1, "R7 stop");

    // R9 byte with start is dropped
    cyc(1, 8'b0_0_011_011, 1, 0, "R9 byte with start");
    word3(8'b0_0_001_010, 8'hDE, 8'hAD, "R9 word after");
    cyc(1, 8'hEE, 0, 1, "R9 byte with stop");
    word3(8'b0_0_101_101, 8'h3C, 8'h5A, "R9 word after stop");

    // R10 idle gaps
    cyc(1, 8'b0_0_010_010, 0, 0, "R10 ctl");
    for (int i = 0; i < 5; i++) cyc(0, 8'hFF, 0, 0, "R10 idle");
    cyc(1, 8'hC0, 0, 0, "R10 hi");
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 0, "R10 idle2");
    cyc(1, 8'hEE, 0, 0, "R10 lo");

    // random mix, R8 checked on every cycle via held fields
    for (int t = 0; t < 300; t++) begin
      int n;
      logic [7:0] c;
      cyc(0, 0, 1, 0, "R8 rnd start");
      c = 8'($urandom);
      c[7] = ($urandom % 8) == 0;
      n = $urandom % 9;
      cyc(1, c, 0, 0, "R8 rnd ctl");
      for (int k = 0; k < n; k++) begin
        if ($urandom % 4 == 0) cyc(0, 8'($urandom), 0, 0, "R10 rnd idle");
        cyc(1, 8'($urandom), 0, 0, "R8 rnd byte");
      end
      if ($urandom % 2 == 0) cyc(0, 0, 0, 1, "R6 rnd stop");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule